// File: doc/BRIEF.md
# Timestamp-Gated Transmit Sample Release

This block sits between a packet buffer RAM and a set of per-channel transmit sample FIFOs. Upstream logic hands it one descriptor per packet. A descriptor carries a 32-bit launch time, a target channel, the RAM buffer that holds the samples and a sample count. Descriptors that pass an ordering check wait in a small in-order queue. A free-running 32-bit sample-time counter gates the head of the queue. Once the counter reaches the head packet's launch time, the block reads the packet's 32-bit I/Q words out of RAM one per cycle and writes them into that channel's FIFO. After the last word it hands the buffer number back for reuse.

Launch times must arrive in non-decreasing order. Any descriptor older than the last accepted one is discarded on arrival and counted. Comparisons use the sign of the 32-bit difference, so the counter and the stamps may wrap. An epoch-start pulse forgets the last accepted stamp so that ordering restarts from a new base. A "send now" flag releases a packet as soon as it reaches the queue head. Such a packet takes no part in the ordering check.

Top module: `tsgate_top`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `timeNow` is 0, `descReady` is 1, and `fifoWr`, `freeValid`, `dropPulse` and `dropCount` are all 0.
- R2: `timeNow` rises by exactly one on every clock after reset.
- R3: A queued packet with launch time T, buffer B and length field L is released at the earliest cycle in which `timeNow - T` has bit 31 clear (reached or passed). If it is already at the queue head when `timeNow == T`, its first FIFO write happens in the cycle with `timeNow == T+2`. Its L+1 words are then written on consecutive cycles, and word k is read from `ramAddr = {B, k}`. A stamp that is already in the past releases at once: a descriptor presented in the cycle with `timeNow == t` first writes at `t+3`.
- R4: The RAM read has one cycle of latency. In the cycle after `ramRdEn`, exactly one bit of `fifoWr` is set: bit `descChan` of the packet. In that cycle `fifoData` equals `ramData` unchanged, with I in bits 31:16 and Q in bits 15:0.
- R5: A descriptor with `descNow = 1` is never dropped and releases as soon as it is at the queue head, whatever its stamp. It does not change the stored last-accepted stamp.
- R6: A descriptor with `descNow = 0` is dropped when a stored stamp P exists and bit 31 of `descTs - P` is set. It is accepted when the difference is zero or positive in that sign sense, which includes a wrap from 0xFFFFFFF0 to 0x00000010. A dropped descriptor produces no FIFO write.
- R7: Each drop raises `dropPulse` for the single cycle after the descriptor was taken. In that same cycle `dropCount` is one higher than before; it saturates at 0xFFFF and otherwise holds.
- R8: An `epochStart` pulse clears the stored stamp. A descriptor taken in the same cycle as the pulse is accepted whatever its stamp, and its stamp becomes the new reference.
- R9: `freeValid` is high, with `freeBuf` equal to the packet's buffer, exactly in the cycle of the packet's last FIFO write.
- R10: Packets leave in the order they were accepted. `descReady` is 0 while QDEPTH (default 4) packets are waiting, and a descriptor offered while `descReady` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| epochStart | input | 1 | Clears the stored last-accepted stamp |
| descValid | input | 1 | Descriptor present this cycle |
| descNow | input | 1 | Release without waiting and skip the ordering check |
| descTs | input | 32 | Packet launch time |
| descChan | input | CH_W (2) | Target channel |
| descBuf | input | BUF_W (2) | RAM buffer holding the samples |
| descLen | input | OFF_W (4) | Number of samples minus one |
| descReady | output | 1 | Queue can take a descriptor |
| timeNow | output | 32 | Free-running sample-time counter |
| ramRdEn | output | 1 | RAM read strobe |
| ramAddr | output | BUF_W+OFF_W (6) | RAM word address {buffer, offset} |
| ramData | input | 32 | RAM read data, one cycle after the strobe |
| fifoWr | output | NCH (4) | Per-channel FIFO write strobes |
| fifoData | output | 32 | Sample word for the FIFOs |
| freeValid | output | 1 | Buffer returned this cycle |
| freeBuf | output | BUF_W (2) | Returned buffer |
| dropPulse | output | 1 | Out-of-order descriptor was discarded |
| dropCount | output | CNT_W (16) | Saturating discard count |

## Verification
An epoch-start pulse and the acceptance of a descriptor can land on the same clock edge. The stamp check must then see the reference as already cleared. The bench provokes this by raising `epochStart` in the cycle it offers a descriptor older than the stored stamp. It judges the result by the absence of a drop pulse, an unchanged `dropCount` and the packet's samples appearing on the channel FIFO. A second overlap arises when descriptors arrive while an earlier packet is being copied. The queue-full scenario exercises this, and arrival order and exact write cycles are checked there.

// File: rtl/tsgate_pkg.sv
package tsgate_pkg;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_COPY = 1'b1
  } relState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic drop;
    logic pop;
    logic issue;
    logic issueLast;
  } relStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic descFire;
    logic inOrder;
    logic headReady;
    logic atLast;
  } relStatus_t;

endpackage

// File: rtl/tsgate_ctrl.sv
module tsgate_ctrl
  import tsgate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descNow,
  input  relStatus_t status,
  output relStrobe_t strobe
);

  relState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    strobe.push = status.descFire & (descNow | status.inOrder);
    strobe.drop = status.descFire & ~descNow & ~status.inOrder;
    case (state)
      ST_WAIT: begin
        if (status.headReady) begin
          strobe.pop = 1'b1;
          stateNext  = ST_COPY;
        end
      end
      ST_COPY: begin
        strobe.issue = 1'b1;
        if (status.atLast) begin
          strobe.issueLast = 1'b1;
          stateNext        = ST_WAIT;
        end
      end
      default: stateNext = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNext;
  end

endmodule

// File: rtl/tsgate_dp.sv
module tsgate_dp
  import tsgate_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NBUF   = 4,
  parameter int MAXLEN = 16,
  parameter int QDEPTH = 4,
  parameter int TS_W   = 32,
  parameter int SMP_W  = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NCH),
  localparam int BUF_W = $clog2(NBUF),
  localparam int OFF_W = $clog2(MAXLEN),
  localparam int PTR_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int QC_W  = $clog2(QDEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   epochStart,
  input  logic                   descValid,
  input  logic                   descNow,
  input  logic [TS_W-1:0]        descTs,
  input  logic [CH_W-1:0]        descChan,
  input  logic [BUF_W-1:0]       descBuf,
  input  logic [OFF_W-1:0]       descLen,
  input  relStrobe_t             strobe,
  output relStatus_t             status,
  output logic                   descReady,
  output logic [TS_W-1:0]        timeNow,
  output logic                   ramRdEn,
  output logic [BUF_W+OFF_W-1:0] ramAddr,
  input  logic [SMP_W-1:0]       ramData,
  output logic [NCH-1:0]         fifoWr,
  output logic [SMP_W-1:0]       fifoData,
  output logic                   freeValid,
  output logic [BUF_W-1:0]       freeBuf,
  output logic                   dropPulse,
  output logic [CNT_W-1:0]       dropCount
);

  // descriptor queue storage
  logic [TS_W-1:0]  qTs   [QDEPTH];
  logic [CH_W-1:0]  qChan [QDEPTH];
  logic [BUF_W-1:0] qBuf  [QDEPTH];
  logic [OFF_W-1:0] qLen  [QDEPTH];
  logic             qNow  [QDEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [QC_W-1:0]  qCount;

  // ordering reference
  logic [TS_W-1:0]  prevTs;
  logic             prevLive;
  logic [TS_W-1:0]  arrivalDiff, headDiff;

  // packet being copied
  logic [CH_W-1:0]  curChan;
  logic [BUF_W-1:0] curBuf;
  logic [OFF_W-1:0] curLen, offset;

  // write pipeline
  logic             wrPend, lastPend;
  logic [CH_W-1:0]  wrChan;
  logic [BUF_W-1:0] retBuf;

  assign descReady   = (qCount != QC_W'(QDEPTH));
  assign arrivalDiff = descTs - prevTs;
  assign headDiff    = timeNow - qTs[rdPtr];

  always_comb begin
    status.descFire  = descValid & descReady;
    // a same-cycle epoch pulse makes the reference count as already cleared
    status.inOrder   = ~(prevLive & ~epochStart) | ~arrivalDiff[TS_W-1];
    status.headReady = (qCount != '0) & (qNow[rdPtr] | ~headDiff[TS_W-1]);
    status.atLast    = (offset == curLen);
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      qTs[wrPtr]   <= descTs;
      qChan[wrPtr] <= descChan;
      qBuf[wrPtr]  <= descBuf;
      qLen[wrPtr]  <= descLen;
      qNow[wrPtr]  <= descNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeNow   <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      qCount    <= '0;
      prevTs    <= '0;
      prevLive  <= 1'b0;
      curChan   <= '0;
      curBuf    <= '0;
      curLen    <= '0;
      offset    <= '0;
      wrPend    <= 1'b0;
      lastPend  <= 1'b0;
      wrChan    <= '0;
      retBuf    <= '0;
      dropPulse <= 1'b0;
      dropCount <= '0;
    end else begin
      timeNow <= timeNow + 1'b1;
      if (strobe.push)
        wrPtr <= (wrPtr == PTR_W'(QDEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)
        rdPtr <= (rdPtr == PTR_W'(QDEPTH - 1)) ? '0 : rdPtr + 1'b1;
      qCount <= qCount + QC_W'(strobe.push) - QC_W'(strobe.pop);

      if (epochStart) prevLive <= 1'b0;
      if (strobe.push && !descNow) begin
        prevTs   <= descTs;
        prevLive <= 1'b1;
      end

      if (strobe.pop) begin
        curChan <= qChan[rdPtr];
        curBuf  <= qBuf[rdPtr];
        curLen  <= qLen[rdPtr];
        offset  <= '0;
      end else if (strobe.issue) begin
        offset  <= offset + 1'b1;
      end

      wrPend   <= strobe.issue;
      lastPend <= strobe.issueLast;
      wrChan   <= curChan;
      retBuf   <= curBuf;

      dropPulse <= strobe.drop;
      if (strobe.drop && dropCount != '1) dropCount <= dropCount + 1'b1;
    end
  end

  assign ramRdEn   = strobe.issue;
  assign ramAddr   = {curBuf, offset};
  assign fifoData  = ramData;
  assign freeValid = lastPend;
  assign freeBuf   = retBuf;

  for (genvar c = 0; c < NCH; c++) begin : g_fifoWr
    assign fifoWr[c] = wrPend && (wrChan == CH_W'(c));
  end

endmodule

// File: rtl/tsgate_top.sv
module tsgate_top
  import tsgate_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NBUF   = 4,
  parameter int MAXLEN = 16,
  parameter int QDEPTH = 4,
  parameter int TS_W   = 32,
  parameter int SMP_W  = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NCH),
  localparam int BUF_W = $clog2(NBUF),
  localparam int OFF_W = $clog2(MAXLEN)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   epochStart,
  input  logic                   descValid,
  input  logic                   descNow,
  input  logic [TS_W-1:0]        descTs,
  input  logic [CH_W-1:0]        descChan,
  input  logic [BUF_W-1:0]       descBuf,
  input  logic [OFF_W-1:0]       descLen,
  output logic                   descReady,
  output logic [TS_W-1:0]        timeNow,
  output logic                   ramRdEn,
  output logic [BUF_W+OFF_W-1:0] ramAddr,
  input  logic [SMP_W-1:0]       ramData,
  output logic [NCH-1:0]         fifoWr,
  output logic [SMP_W-1:0]       fifoData,
  output logic                   freeValid,
  output logic [BUF_W-1:0]       freeBuf,
  output logic                   dropPulse,
  output logic [CNT_W-1:0]       dropCount
);

  relStrobe_t strobe;
  relStatus_t status;

  tsgate_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .descNow(descNow),
    .status (status),
    .strobe (strobe)
  );

  tsgate_dp #(
    .NCH(NCH), .NBUF(NBUF), .MAXLEN(MAXLEN), .QDEPTH(QDEPTH),
    .TS_W(TS_W), .SMP_W(SMP_W), .CNT_W(CNT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .epochStart(epochStart),
    .descValid (descValid),
    .descNow   (descNow),
    .descTs    (descTs),
    .descChan  (descChan),
    .descBuf   (descBuf),
    .descLen   (descLen),
    .strobe    (strobe),
    .status    (status),
    .descReady (descReady),
    .timeNow   (timeNow),
    .ramRdEn   (ramRdEn),
    .ramAddr   (ramAddr),
    .ramData   (ramData),
    .fifoWr    (fifoWr),
    .fifoData  (fifoData),
    .freeValid (freeValid),
    .freeBuf   (freeBuf),
    .dropPulse (dropPulse),
    .dropCount (dropCount)
  );

endmodule

// File: rtl/tsgate_chk.sv
module tsgate_chk #(
  parameter int NCH   = 4,
  parameter int TS_W  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ramRdEn,
  input logic [NCH-1:0]   fifoWr,
  input logic             freeValid,
  input logic             dropPulse,
  input logic [CNT_W-1:0] dropCount,
  input logic [TS_W-1:0]  timeNow
);

  assert_time_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (timeNow == $past(timeNow) + 1'b1));

  assert_one_channel_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fifoWr));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramRdEn |=> (fifoWr != '0));

  assert_drop_increments_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dropPulse && $past(dropCount) != '1) |-> (dropCount == $past(dropCount) + 1'b1));

  assert_count_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dropPulse |-> $stable(dropCount));

  assert_free_on_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> (fifoWr != '0));

endmodule

bind tsgate_top tsgate_chk #(.NCH(NCH), .TS_W(TS_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/tsgate_top_tb_top.sv
`timescale 1ns/1ps
module tsgate_top_tb_top;

  localparam int NCH = 4, BUF_W = 2, OFF_W = 4, AW = BUF_W + OFF_W;

  logic clk = 1'b0, rstN = 1'b0;
  logic epochStart = 1'b0, descValid = 1'b0, descNow = 1'b0;
  logic [31:0] descTs = '0;
  logic [1:0] descChan = '0;
  logic [BUF_W-1:0] descBuf = '0;
  logic [OFF_W-1:0] descLen = '0;
  logic descReady, ramRdEn, freeValid, dropPulse;
  logic [31:0] timeNow, fifoData;
  logic [31:0] ramData = '0;
  logic [AW-1:0] ramAddr;
  logic [NCH-1:0] fifoWr;
  logic [BUF_W-1:0] freeBuf;
  logic [15:0] dropCount;

  int total = 0, bad = 0, expDrops = 0;
  logic [31:0] lastTs;

  always #4 clk = ~clk;

  tsgate_top dut_i (.*);

  function automatic logic [31:0] pat(input logic [AW-1:0] a);
    return {16'h1000 + {10'd0, a}, 16'hF000 - {10'd0, a}};
  endfunction

  always @(posedge clk) ramData <= pat(ramAddr);

  // output log
  logic [31:0] wrT [256];
  int          wrCh[256];
  logic [31:0] wrD [256];
  logic [31:0] frT [64];
  int          frB [64];
  int wrN = 0, frN = 0, multiHit = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (fifoWr != '0) begin
        if ($countones(fifoWr) > 1) multiHit++;
        for (int c = 0; c < NCH; c++) if (fifoWr[c]) wrCh[wrN] = c;
        wrT[wrN] = timeNow;
        wrD[wrN] = fifoData;
        wrN++;
      end
      if (freeValid) begin
        frT[frN] = timeNow;
        frB[frN] = int'(freeBuf);
        frN++;
      end
    end
  end

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sendDesc(input logic [31:0] ts, input int ch, input int bufv,
                          input int len, input bit now, input bit epoch,
                          output logic [31:0] t, output bit dropSeen, output bit rdy);
    @(negedge clk);
    t = timeNow;
    rdy = descReady;
    descValid = 1'b1; descTs = ts; descChan = 2'(ch); descBuf = BUF_W'(bufv);
    descLen = OFF_W'(len); descNow = now; epochStart = epoch;
    @(negedge clk);
    dropSeen = dropPulse;
    descValid = 1'b0; descNow = 1'b0; epochStart = 1'b0;
  endtask

  task automatic waitWrites(input int n);
    int k = 0;
    while (wrN < n && k < 1000) begin
      @(negedge clk);
      k++;
    end
    @(negedge clk);
  endtask

  task automatic checkPkt(input int wIdx, input int fIdx, input logic [31:0] expT,
                          input int ch, input int bufv, input int len, input string req);
    for (int k = 0; k <= len; k++) begin
      chkEq(req, "write cycle", wrT[wIdx+k], expT + k);
      chkEq("R4", "channel", wrCh[wIdx+k], ch);
      chkEq("R4", "data", wrD[wIdx+k], pat({BUF_W'(bufv), OFF_W'(k)}));
    end
    chkEq("R9", "free buffer", frB[fIdx], bufv);
    chkEq("R9", "free cycle", frT[fIdx], expT + len);
  endtask

  task automatic testReset;
    chkEq("R1", "timeNow", timeNow, 0);
    chkEq("R1", "descReady", descReady, 1);
    chkEq("R1", "fifoWr", fifoWr, 0);
    chkEq("R1", "freeValid", freeValid, 0);
    chkEq("R1", "dropPulse", dropPulse, 0);
    chkEq("R1", "dropCount", dropCount, 0);
    repeat (7) @(negedge clk);
    chkEq("R2", "timeNow step", timeNow, 7);
  endtask

  task automatic testTimed;
    logic [31:0] t, ts; bit d, r; int w = wrN, f = frN;
    @(negedge clk);
    ts = timeNow + 20;
    sendDesc(ts, 1, 2, 3, 0, 0, t, d, r);
    chkEq("R6", "no drop", d, 0);
    waitWrites(w + 4);
    checkPkt(w, f, ts + 2, 1, 2, 3, "R3");
    lastTs = ts;
  endtask

  task automatic testLate;
    logic [31:0] t, tt, ts; bit d, r; int w = wrN, f = frN;
    @(negedge clk);
    tt = timeNow;
    ts = tt - 4;
    sendDesc(ts, 2, 3, 0, 0, 0, t, d, r);
    chkEq("R3", "late no drop", d, 0);
    waitWrites(w + 1);
    checkPkt(w, f, t + 3, 2, 3, 0, "R3");
    lastTs = ts;
  endtask

  task automatic testImmediate;
    logic [31:0] t; bit d, r; int w = wrN, f = frN;
    sendDesc(32'h0, 3, 1, 1, 1, 0, t, d, r);
    chkEq("R5", "immediate no drop", d, 0);
    waitWrites(w + 2);
    checkPkt(w, f, t + 3, 3, 1, 1, "R5");
    // reference must still be lastTs, so one below it is dropped
    sendDesc(lastTs - 1, 0, 0, 0, 0, 0, t, d, r);
    expDrops++;
    chkEq("R5", "reference kept", d, 1);
    chkEq("R7", "dropCount", dropCount, expDrops);
  endtask

  task automatic testOrder;
    logic [31:0] t; bit d, r; int w = wrN;
    sendDesc(lastTs, 0, 2, 0, 0, 0, t, d, r);
    chkEq("R6", "equal accepted", d, 0);
    waitWrites(w + 1);
    chkEq("R6", "equal released", wrN, w + 1);
    w = wrN;
    sendDesc(lastTs - 100, 1, 0, 0, 0, 0, t, d, r);
    expDrops++;
    chkEq("R6", "older dropped", d, 1);
    chkEq("R7", "dropCount", dropCount, expDrops);
    @(negedge clk);
    chkEq("R7", "pulse one cycle", dropPulse, 0);
    repeat (10) @(negedge clk);
    chkEq("R6", "dropped not written", wrN, w);
  endtask

  task automatic testWrap;
    logic [31:0] t; bit d, r; int w = wrN;
    sendDesc(32'hFFFF_FFF0, 0, 1, 0, 0, 1, t, d, r);
    chkEq("R6", "pre-wrap accepted", d, 0);
    sendDesc(32'h0000_0010, 1, 2, 0, 0, 0, t, d, r);
    chkEq("R6", "wrapped accepted", d, 0);
    sendDesc(32'hFFFF_FFF8, 2, 3, 0, 0, 0, t, d, r);
    expDrops++;
    chkEq("R6", "behind wrap dropped", d, 1);
    waitWrites(w + 2);
    chkEq("R6", "wrap writes", wrN, w + 2);
    chkEq("R7", "dropCount", dropCount, expDrops);
  endtask

  task automatic testEpoch;
    logic [31:0] t; bit d, r; int w = wrN, f = frN;
    // epoch and an older descriptor in the same cycle
    sendDesc(32'h5, 3, 0, 1, 0, 1, t, d, r);
    chkEq("R8", "same-cycle epoch no drop", d, 0);
    waitWrites(w + 2);
    checkPkt(w, f, t + 3, 3, 0, 1, "R8");
    chkEq("R8", "dropCount unchanged", dropCount, expDrops);
    @(negedge clk); epochStart = 1'b1;
    @(negedge clk); epochStart = 1'b0;
    w = wrN;
    sendDesc(32'h2, 0, 3, 0, 0, 0, t, d, r);
    chkEq("R8", "epoch alone clears", d, 0);
    sendDesc(32'h1, 0, 3, 0, 0, 0, t, d, r);
    expDrops++;
    chkEq("R8", "new reference used", d, 1);
    waitWrites(w + 1);
    chkEq("R8", "epoch writes", wrN, w + 1);
  endtask

  task automatic testQueueFull;
    logic [31:0] t, tA; bit d, r; int w = wrN;
    @(negedge clk);
    tA = timeNow + 300;
    for (int k = 0; k < 4; k++) begin
      sendDesc(tA + k, k, k, 0, 0, 0, t, d, r);
      chkEq("R10", "ready while filling", r, 1);
    end
    sendDesc(tA + 10, 0, 0, 2, 0, 0, t, d, r);
    chkEq("R10", "ready low when full", r, 0);
    waitWrites(w + 4);
    for (int k = 0; k < 4; k++) begin
      chkEq("R10", "order channel", wrCh[w+k], k);
      chkEq("R10", "order cycle", wrT[w+k], tA + 2 + 2 * k);
      chkEq("R10", "order data", wrD[w+k], pat({BUF_W'(k), OFF_W'(0)}));
    end
    repeat (40) @(negedge clk);
    chkEq("R10", "offer while full ignored", wrN, w + 4);
    lastTs = tA + 3;
  endtask

  task automatic testSaturate;
    int target;
    @(negedge clk);
    descValid = 1'b1; descNow = 1'b0; descTs = lastTs - 3;
    repeat (5) @(negedge clk);
    expDrops += 5;
    chkEq("R7", "count while dropping", dropCount, expDrops);
    chkEq("R7", "pulse while dropping", dropPulse, 1);
    repeat (65540) @(negedge clk);
    descValid = 1'b0;
    target = expDrops + 65540;
    if (target > 65535) target = 65535;
    chkEq("R7", "saturated", dropCount, target);
    @(negedge clk);
    chkEq("R7", "pulse ends", dropPulse, 0);
    chkEq("R7", "holds at max", dropCount, 16'hFFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chkEq("R1", "fifoWr in reset", fifoWr, 0);
    chkEq("R1", "dropCount in reset", dropCount, 0);
    rstN = 1'b1;
    testReset();
    testTimed();
    testLate();
    testImmediate();
    testOrder();
    testWrap();
    testEpoch();
    testQueueFull();
    chkEq("R4", "single channel per write", multiHit, 0);
    testSaturate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule